// File: doc/BRIEF.md
# Ray Dispatch and Return Arbiter

This block sits between a single stream of new rays and four traversal units that share one triangle-intersection unit. It takes at most one ray per cycle from the incoming stream, in arrival order, and hands it to a traversal unit that still has a free ray slot. Each traversal unit may hold up to sixteen rays at once. The hub counts occupancy per unit, and it stops accepting rays when all four units are full.

Traversal units that reach a leaf raise a leaf request. A round-robin merge stage feeds these requests into the intersection input and tags each ray with the 2-bit index of the unit that sent it. The intersection unit keeps a ray internally while triangles remain in its leaf. When the leaf is exhausted it presents the ray with its tag, and the hub routes that ray back to the traversal unit named in the tag. Rays that have finished traversal are merged round-robin onto one shader output with a valid/ready handshake. A ray slot is released only when its ray is taken into that shader merge.

Both merge stages are instances of one two-state machine. In `MS_EMPTY` the stage has no output; any request moves it to `MS_FULL` (capture). In `MS_FULL` it presents the held ray; it stays in `MS_FULL` while stalled (hold) or while it captures a new request in the same cycle the old one is accepted (pass-on). It returns to `MS_EMPTY` when the output is accepted and no request is pending (drain).

Top module: `ray_dispatch_hub`

## Requirements
- R1: After reset every slot count is zero, `ray_in_ready` is 1, and `issue_valid`, `isect_in_valid` and `shd_valid` are 0.
- R2: When `ray_in_valid` and `ray_in_ready` are both 1, exactly one bit of `issue_valid` is 1 in that same cycle, and `issue_data` equals `ray_in_data`. No bit of `issue_valid` is 1 when `ray_in_valid` is 0.
- R3: The receiving unit is chosen round-robin among units that are not full. The search starts at the unit after the last one that received a ray, and at unit 0 after reset. Full units are skipped.
- R4: A unit holding 16 rays receives no ray. When all four units are full, `ray_in_ready` is 0 and no `issue_valid` bit is set.
- R5: A unit's count drops only when one of its finished rays is accepted (`fin_valid[i]` and `fin_ready[i]` both 1). Leaf requests and intersection returns leave the counts unchanged.
- R6: Leaf requests are granted round-robin through the one-hot `leaf_ready`, starting from unit 0 after reset and from the unit after the last grant afterwards. A ray granted in cycle t appears on `isect_in_data` in cycle t+1 with `isect_in_tag` equal to the binary index of the sending unit.
- R7: While a merge output is valid and not accepted (`isect_in_valid` with `isect_in_ready` at 0, or `shd_valid` with `shd_ready` at 0), that output's data and tag stay unchanged and its side grants nothing.
- R8: When `isect_out_valid` is 1, only `ret_valid[isect_out_tag]` is 1 in that same cycle, and `ret_data` equals `isect_out_data`.
- R9: Finished rays are granted round-robin through `fin_ready` under the same pointer rule as R6. A ray granted in cycle t appears on `shd_data` in cycle t+1, and `shd_src` holds the index of its unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ray_in_valid | input | 1 | New ray offered |
| ray_in_ready | output | 1 | Some unit has a free slot |
| ray_in_data | input | RAY_W | New ray payload |
| issue_valid | output | NUM_TRV | One-hot ray handed to a traversal unit |
| issue_data | output | RAY_W | Ray handed out |
| leaf_valid | input | NUM_TRV | Per-unit leaf request |
| leaf_data | input | NUM_TRV*RAY_W | Per-unit leaf ray, unit i at slice i |
| leaf_ready | output | NUM_TRV | One-hot leaf grant |
| isect_in_valid | output | 1 | Ray presented to intersection |
| isect_in_data | output | RAY_W | Ray to intersection |
| isect_in_tag | output | TAG_W | Owner unit of that ray |
| isect_in_ready | input | 1 | Intersection accepts ray |
| isect_out_valid | input | 1 | Leaf finished, ray returning |
| isect_out_data | input | RAY_W | Returning ray |
| isect_out_tag | input | TAG_W | Owner of returning ray |
| ret_valid | output | NUM_TRV | One-hot return to owner unit |
| ret_data | output | RAY_W | Returned ray |
| fin_valid | input | NUM_TRV | Per-unit finished ray |
| fin_data | input | NUM_TRV*RAY_W | Per-unit finished ray, unit i at slice i |
| fin_ready | output | NUM_TRV | One-hot retire grant |
| shd_valid | output | 1 | Finished ray to shader |
| shd_data | output | RAY_W | Finished ray |
| shd_src | output | TAG_W | Unit the finished ray came from |
| shd_ready | input | 1 | Shader accepts ray |

## Verification
On every cycle the assertions check the following: slot counts never exceed sixteen or fall below zero, a full unit is never chosen, a count never falls without a retire, issue and grant vectors are one-hot, stalled merge outputs hold steady, and each return reaches exactly one unit. Some properties can only be shown by the directed scenarios. These are the exact round-robin order of dispatch, leaf grants and retires; the skipping of full units when slots reopen; and that intersection traffic never reopens a slot. The scenarios also confirm that the tag and the source index carry the correct unit number.

// File: rtl/rdh_pkg.sv
package rdh_pkg;
    localparam int NUM_TRV   = 4;
    localparam int TRV_SLOTS = 16;
    localparam int RAY_W     = 16;

    typedef enum logic {
        MS_EMPTY = 1'b0,
        MS_FULL  = 1'b1
    } merge_state_e;
endpackage

// File: rtl/rdh_rr_pick.sv
module rdh_rr_pick #(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] ptr,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] gnt_idx,
    output logic          any
);
    // first requester at or after ptr, wrapping
    always_comb begin
        gnt     = '0;
        gnt_idx = '0;
        any     = 1'b0;
        for (int k = 0; k < N; k++) begin
            int idx;
            idx = int'(ptr) + k;
            if (idx >= N) idx = idx - N;
            if (!any && req[idx]) begin
                any      = 1'b1;
                gnt[idx] = 1'b1;
                gnt_idx  = IW'(idx);
            end
        end
    end
endmodule

// File: rtl/rdh_slot_ctr.sv
module rdh_slot_ctr #(
    parameter int CAP = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    output logic full
);
    localparam int CW = $clog2(CAP + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            unique case ({inc, dec})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    assign full = (cnt == CW'(CAP));

    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(CAP));
    a_r4_full_takes_none: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !inc);
    a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0) |-> !dec);
    a_r5_free_only_on_retire: assert property (@(posedge clk) disable iff (!rst_n)
        !dec |=> (cnt >= $past(cnt)));
endmodule

// File: rtl/rdh_merge_stage.sv
module rdh_merge_stage
    import rdh_pkg::*;
#(
    parameter int N  = 4,
    parameter int DW = 16,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req_valid,
    input  logic [N*DW-1:0] req_data,
    output logic [N-1:0]  req_ready,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    output logic [IW-1:0] out_src,
    input  logic          out_ready
);
    merge_state_e  state, state_nx;
    logic [IW-1:0] ptr;
    logic [N-1:0]  gnt;
    logic [IW-1:0] gnt_idx;
    logic          any;
    logic          take;

    rdh_rr_pick #(.N(N), .IW(IW)) u_pick (
        .req     (req_valid),
        .ptr     (ptr),
        .gnt     (gnt),
        .gnt_idx (gnt_idx),
        .any     (any)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= MS_EMPTY;
        else        state <= state_nx;
    end

    // transitions: capture, hold, pass-on, drain
    always_comb begin
        state_nx = state;
        unique case (state)
            MS_EMPTY: state_nx = any ? MS_FULL : MS_EMPTY;
            MS_FULL:  state_nx = (out_ready && !any) ? MS_EMPTY : MS_FULL;
            default:  state_nx = MS_EMPTY;
        endcase
    end

    // outputs
    always_comb begin
        take = 1'b0;
        unique case (state)
            MS_EMPTY: take = any;
            MS_FULL:  take = any && out_ready;
            default:  take = 1'b0;
        endcase
        out_valid = (state == MS_FULL);
        req_ready = take ? gnt : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr      <= '0;
            out_data <= '0;
            out_src  <= '0;
        end else if (take) begin
            out_data <= req_data[gnt_idx*DW +: DW];
            out_src  <= gnt_idx;
            ptr      <= (gnt_idx == IW'(N - 1)) ? '0 : gnt_idx + IW'(1);
        end
    end

    a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_src)));
    a_r7_no_grant_in_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> (req_ready == '0));
    a_r6_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_ready));
    a_r6_grant_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_ready & ~req_valid) == '0));
endmodule

// File: rtl/ray_dispatch_hub.sv
module ray_dispatch_hub
    import rdh_pkg::*;
#(
    parameter int NTRV  = NUM_TRV,
    parameter int SLOTS = TRV_SLOTS,
    parameter int RW    = RAY_W,
    parameter int TAG_W = (NTRV > 1) ? $clog2(NTRV) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ray_in_valid,
    output logic               ray_in_ready,
    input  logic [RW-1:0]      ray_in_data,
    output logic [NTRV-1:0]    issue_valid,
    output logic [RW-1:0]      issue_data,
    input  logic [NTRV-1:0]    leaf_valid,
    input  logic [NTRV*RW-1:0] leaf_data,
    output logic [NTRV-1:0]    leaf_ready,
    output logic               isect_in_valid,
    output logic [RW-1:0]      isect_in_data,
    output logic [TAG_W-1:0]   isect_in_tag,
    input  logic               isect_in_ready,
    input  logic               isect_out_valid,
    input  logic [RW-1:0]      isect_out_data,
    input  logic [TAG_W-1:0]   isect_out_tag,
    output logic [NTRV-1:0]    ret_valid,
    output logic [RW-1:0]      ret_data,
    input  logic [NTRV-1:0]    fin_valid,
    input  logic [NTRV*RW-1:0] fin_data,
    output logic [NTRV-1:0]    fin_ready,
    output logic               shd_valid,
    output logic [RW-1:0]      shd_data,
    output logic [TAG_W-1:0]   shd_src,
    input  logic               shd_ready
);
    logic [NTRV-1:0]  unit_full;
    logic [NTRV-1:0]  unit_open;
    logic [NTRV-1:0]  pick_gnt;
    logic [TAG_W-1:0] pick_idx;
    logic             pick_any;
    logic [TAG_W-1:0] disp_ptr;
    logic             accept;
    logic [NTRV-1:0]  retire;

    assign unit_open = ~unit_full;

    rdh_rr_pick #(.N(NTRV), .IW(TAG_W)) u_disp_pick (
        .req     (unit_open),
        .ptr     (disp_ptr),
        .gnt     (pick_gnt),
        .gnt_idx (pick_idx),
        .any     (pick_any)
    );

    assign ray_in_ready = pick_any;
    assign accept       = ray_in_valid && pick_any;
    assign issue_valid  = accept ? pick_gnt : '0;
    assign issue_data   = ray_in_data;

    always_ff @(posedge clk) begin
        if (!rst_n)      disp_ptr <= '0;
        else if (accept) disp_ptr <= (pick_idx == TAG_W'(NTRV - 1)) ? '0 : pick_idx + TAG_W'(1);
    end

    assign retire = fin_valid & fin_ready;

    for (genvar g = 0; g < NTRV; g++) begin : g_slots
        rdh_slot_ctr #(.CAP(SLOTS)) u_ctr (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (issue_valid[g]),
            .dec   (retire[g]),
            .full  (unit_full[g])
        );
    end

    rdh_merge_stage #(.N(NTRV), .DW(RW), .IW(TAG_W)) u_leaf_merge (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (leaf_valid),
        .req_data  (leaf_data),
        .req_ready (leaf_ready),
        .out_valid (isect_in_valid),
        .out_data  (isect_in_data),
        .out_src   (isect_in_tag),
        .out_ready (isect_in_ready)
    );

    always_comb begin
        ret_valid = '0;
        if (isect_out_valid) ret_valid[isect_out_tag] = 1'b1;
    end
    assign ret_data = isect_out_data;

    rdh_merge_stage #(.N(NTRV), .DW(RW), .IW(TAG_W)) u_fin_merge (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (fin_valid),
        .req_data  (fin_data),
        .req_ready (fin_ready),
        .out_valid (shd_valid),
        .out_data  (shd_data),
        .out_src   (shd_src),
        .out_ready (shd_ready)
    );

    a_r2_single_issue: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(issue_valid));
    a_r2_issue_needs_ray: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid != '0) |-> ray_in_valid);
    a_r4_stall_when_all_full: assert property (@(posedge clk) disable iff (!rst_n)
        (&unit_full) |-> (issue_valid == '0));
    a_r8_return_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        isect_out_valid |-> $onehot(ret_valid));
    a_r8_no_spurious_return: assert property (@(posedge clk) disable iff (!rst_n)
        !isect_out_valid |-> (ret_valid == '0));
endmodule

// File: tb/sim_ray_dispatch_hub.sv
module sim_ray_dispatch_hub;
    localparam int N  = 4;
    localparam int RW = 16;
    localparam int TW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ray_in_valid = 1'b0;
    logic          ray_in_ready;
    logic [RW-1:0] ray_in_data = '0;
    logic [N-1:0]  issue_valid;
    logic [RW-1:0] issue_data;
    logic [N-1:0]  leaf_valid = '0;
    logic [N*RW-1:0] leaf_data = '0;
    logic [N-1:0]  leaf_ready;
    logic          isect_in_valid;
    logic [RW-1:0] isect_in_data;
    logic [TW-1:0] isect_in_tag;
    logic          isect_in_ready = 1'b1;
    logic          isect_out_valid = 1'b0;
    logic [RW-1:0] isect_out_data = '0;
    logic [TW-1:0] isect_out_tag = '0;
    logic [N-1:0]  ret_valid;
    logic [RW-1:0] ret_data;
    logic [N-1:0]  fin_valid = '0;
    logic [N*RW-1:0] fin_data = '0;
    logic [N-1:0]  fin_ready;
    logic          shd_valid;
    logic [RW-1:0] shd_data;
    logic [TW-1:0] shd_src;
    logic          shd_ready = 1'b1;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    ray_dispatch_hub u0 (
        .clk(clk), .rst_n(rst_n),
        .ray_in_valid(ray_in_valid), .ray_in_ready(ray_in_ready), .ray_in_data(ray_in_data),
        .issue_valid(issue_valid), .issue_data(issue_data),
        .leaf_valid(leaf_valid), .leaf_data(leaf_data), .leaf_ready(leaf_ready),
        .isect_in_valid(isect_in_valid), .isect_in_data(isect_in_data),
        .isect_in_tag(isect_in_tag), .isect_in_ready(isect_in_ready),
        .isect_out_valid(isect_out_valid), .isect_out_data(isect_out_data),
        .isect_out_tag(isect_out_tag),
        .ret_valid(ret_valid), .ret_data(ret_data),
        .fin_valid(fin_valid), .fin_data(fin_data), .fin_ready(fin_ready),
        .shd_valid(shd_valid), .shd_data(shd_data), .shd_src(shd_src), .shd_ready(shd_ready)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    // one ray offered at a negedge, checked before the accepting edge
    task automatic send(input logic [RW-1:0] id, input int unit);
        @(negedge clk);
        ray_in_valid = 1'b1;
        ray_in_data  = id;
        #1;
        chk("R3 issue unit", 32'(issue_valid), 32'(1 << unit));
        chk("R2 issue data", 32'(issue_data), 32'(id));
        @(posedge clk);
    endtask

    task automatic stop_send();
        @(negedge clk);
        ray_in_valid = 1'b0;
    endtask

    task automatic t_reset();
        #1;
        chk("R1 ray_in_ready", 32'(ray_in_ready), 32'd1);
        chk("R1 issue_valid", 32'(issue_valid), 32'd0);
        chk("R1 isect_in_valid", 32'(isect_in_valid), 32'd0);
        chk("R1 shd_valid", 32'(shd_valid), 32'd0);
    endtask

    task automatic t_dispatch_order();
        for (int k = 0; k < 8; k++) send(RW'(k + 1), k % 4);
        stop_send();
    endtask

    task automatic t_fill_and_stall();
        for (int k = 8; k < 64; k++) send(RW'(16'h100 + k), k % 4);
        @(negedge clk);
        ray_in_valid = 1'b1;
        ray_in_data  = 16'h0EEE;
        #1;
        chk("R4 ray_in_ready when full", 32'(ray_in_ready), 32'd0);
        chk("R4 no issue when full", 32'(issue_valid), 32'd0);
        @(negedge clk);
        ray_in_valid = 1'b0;
    endtask

    task automatic t_leaf_rr();
        isect_in_ready = 1'b1;
        for (int i = 0; i < N; i++) leaf_data[i*RW +: RW] = RW'(16'h0A00 + i);
        leaf_valid = 4'b1111;
        for (int c = 0; c < N; c++) begin
            #1;
            chk("R6 leaf grant order", 32'(leaf_ready), 32'(1 << c));
            if (c > 0) begin
                chk("R6 isect_in_valid", 32'(isect_in_valid), 32'd1);
                chk("R6 isect_in_tag", 32'(isect_in_tag), 32'(c - 1));
                chk("R6 isect_in_data", 32'(isect_in_data), 32'(16'h0A00 + c - 1));
            end
            @(posedge clk);
            @(negedge clk);
            leaf_valid[c] = 1'b0;
        end
        #1;
        chk("R6 last tag", 32'(isect_in_tag), 32'd3);
        chk("R6 last data", 32'(isect_in_data), 32'h0A03);
        @(negedge clk);
        #1;
        chk("R6 drained", 32'(isect_in_valid), 32'd0);
    endtask

    task automatic t_leaf_stall();
        @(negedge clk);
        isect_in_ready = 1'b0;
        leaf_data[2*RW +: RW] = 16'h0B02;
        leaf_data[1*RW +: RW] = 16'h0B01;
        leaf_valid = 4'b0100;
        #1;
        chk("R6 grant unit 2", 32'(leaf_ready), 32'b0100);
        @(negedge clk);
        leaf_valid = 4'b0010;
        for (int c = 0; c < 3; c++) begin
            #1;
            chk("R7 held valid", 32'(isect_in_valid), 32'd1);
            chk("R7 held tag", 32'(isect_in_tag), 32'd2);
            chk("R7 held data", 32'(isect_in_data), 32'h0B02);
            chk("R7 no grant in stall", 32'(leaf_ready), 32'd0);
            @(negedge clk);
        end
        isect_in_ready = 1'b1;
        #1;
        chk("R6 grant after stall", 32'(leaf_ready), 32'b0010);
        @(negedge clk);
        leaf_valid = 4'b0000;
        #1;
        chk("R6 tag after stall", 32'(isect_in_tag), 32'd1);
        chk("R6 data after stall", 32'(isect_in_data), 32'h0B01);
        @(negedge clk);
    endtask

    task automatic t_return();
        isect_out_valid = 1'b1;
        isect_out_tag   = 2'd3;
        isect_out_data  = 16'h0BB3;
        #1;
        chk("R8 return to unit 3", 32'(ret_valid), 32'b1000);
        chk("R8 return data", 32'(ret_data), 32'h0BB3);
        @(negedge clk);
        isect_out_tag  = 2'd0;
        isect_out_data = 16'h0BB0;
        #1;
        chk("R8 return to unit 0", 32'(ret_valid), 32'b0001);
        chk("R8 return data 0", 32'(ret_data), 32'h0BB0);
        @(negedge clk);
        isect_out_valid = 1'b0;
        ray_in_valid    = 1'b1;
        #1;
        chk("R8 idle return", 32'(ret_valid), 32'd0);
        chk("R5 leaf traffic frees nothing", 32'(ray_in_ready), 32'd0);
        chk("R5 still no issue", 32'(issue_valid), 32'd0);
        @(negedge clk);
        ray_in_valid = 1'b0;
    endtask

    task automatic t_retire_one();
        shd_ready = 1'b1;
        fin_data[1*RW +: RW] = 16'h0C01;
        fin_valid = 4'b0010;
        #1;
        chk("R9 retire grant", 32'(fin_ready), 32'b0010);
        @(negedge clk);
        fin_valid = 4'b0000;
        #1;
        chk("R9 shd_valid", 32'(shd_valid), 32'd1);
        chk("R9 shd_src", 32'(shd_src), 32'd1);
        chk("R9 shd_data", 32'(shd_data), 32'h0C01);
        chk("R5 retire frees slot", 32'(ray_in_ready), 32'd1);
        send(16'h0D01, 1);
        stop_send();
    endtask

    task automatic t_retire_merge();
        shd_ready = 1'b0;
        fin_data[0*RW +: RW] = 16'h0C10;
        fin_data[2*RW +: RW] = 16'h0C12;
        fin_data[3*RW +: RW] = 16'h0C13;
        fin_valid = 4'b1101;
        #1;
        chk("R9 retire rr start", 32'(fin_ready), 32'b0100);
        @(negedge clk);
        fin_valid = 4'b1001;
        for (int c = 0; c < 2; c++) begin
            #1;
            chk("R7 shd held src", 32'(shd_src), 32'd2);
            chk("R7 shd held data", 32'(shd_data), 32'h0C12);
            chk("R7 shd no grant", 32'(fin_ready), 32'd0);
            @(negedge clk);
        end
        shd_ready = 1'b1;
        #1;
        chk("R9 retire rr next", 32'(fin_ready), 32'b1000);
        @(negedge clk);
        fin_valid = 4'b0001;
        #1;
        chk("R9 src 3", 32'(shd_src), 32'd3);
        chk("R9 retire rr wrap", 32'(fin_ready), 32'b0001);
        @(negedge clk);
        fin_valid = 4'b0000;
        #1;
        chk("R9 src 0", 32'(shd_src), 32'd0);
        chk("R9 data 0", 32'(shd_data), 32'h0C10);
        @(negedge clk);
        #1;
        chk("R9 drained", 32'(shd_valid), 32'd0);
        send(16'h0E02, 2);
        send(16'h0E03, 3);
        send(16'h0E00, 0);
        @(negedge clk);
        #1;
        chk("R4 full again", 32'(ray_in_ready), 32'd0);
        chk("R4 no issue again", 32'(issue_valid), 32'd0);
        ray_in_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_dispatch_order();
        t_fill_and_stall();
        t_leaf_rr();
        t_leaf_stall();
        t_return();
        t_retire_one();
        t_retire_merge();
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule